// File: doc/BRIEF.md
# Single-Precision to Small-Float Converter

This block turns one 32-bit single-precision value into one of three narrow floating-point encodings. The first is a signed 16-bit float. The other two are unsigned 11-bit and 10-bit floats, which have no sign bit. The caller picks the target with a 2-bit select. The packed code comes out right-aligned in a 16-bit word, one cycle after the request, together with a valid flag.

All three targets use a 5-bit exponent biased by 15 and a hidden leading one:

- The 16-bit target has 10 fraction bits and a sign in bit 15.
- The 11-bit target has 6 fraction bits.
- The 10-bit target has 5 fraction bits.

The converter handles the following cases:

- Rebiasing the exponent.
- Rounding the fraction to nearest, ties to even.
- Producing denormal codes for small magnitudes instead of flushing them.
- Saturating overflow to infinity.
- Emitting a quiet NaN.
- Clamping negative inputs to zero for the two unsigned targets.

The block accepts one request per cycle with no back-pressure. It is used wherever shader or texture data has to be stored in compact channel formats.

Top module: `fp32_to_minifloat`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock, and `out_code` carries the result of the request accepted on that edge. While `rst_n` is low, both outputs are zero.
- R2: The select values are 0 for the signed 16-bit format, 1 for the unsigned 11-bit format and 2 for the unsigned 10-bit format. Code 3 gives an all-zero word. Output bits above the selected width are zero.
- R3: For a normal 16-bit result the layout is {sign, exp[4:0], frac[9:0]} with the exponent biased by 15. The fraction is rounded to nearest with ties to even, and a rounding carry propagates into the exponent.
- R4: A finite input whose rounded magnitude exceeds the largest finite value of the target becomes infinity. That is exponent 31 with a zero fraction, carrying the input sign in the 16-bit format.
- R5: Magnitudes below 2^-14 produce denormal codes (exponent 0, value frac·2^-14/2^FW) rounded to nearest even. A result that rounds up to 2^-14 becomes the smallest normal code.
- R6: A NaN input gives exponent 31 with only the fraction MSB set. In the 16-bit format the sign bit copies the input sign. In the unsigned formats a NaN with the sign set still gives NaN.
- R7: Infinite inputs give exponent 31 with a zero fraction. Zero inputs and single-precision denormal inputs give zero. The 16-bit format keeps the input sign in both cases.
- R8: For the 11-bit and 10-bit formats, any input with the sign bit set that is not NaN gives zero. This includes -0 and -infinity.
- R9: The 11-bit layout is {exp[4:0], frac[5:0]} and the 10-bit layout is {exp[4:0], frac[4:0]}. Both are biased by 15 and rounded to nearest with ties to even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A conversion request is present this cycle |
| in_value | input | 32 | Single-precision source value |
| fmt_sel | input | 2 | Target format: 0 = 16-bit, 1 = 11-bit, 2 = 10-bit, 3 = reserved |
| out_valid | output | 1 | Registered result is valid |
| out_code | output | 16 | Right-aligned packed result, upper bits zero |

## Verification
All state sits in one output register, so a wrong internal value shows up at the ports on the very next cycle. It appears as a code whose exponent field is off by the rounding carry, as a sign leaking into an unsigned code, or as a valid flag that lags or leads its request. The subtle faults are in the rounding decision: a tie that rounds away from even, or a sticky bit dropped at the denormal shift, changes only the least significant bit. For that reason the stimulus places values exactly on ties and one step above them, at the denormal floor, and at the carry into the smallest normal and into infinity.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam int EXP_W    = 5;
    localparam int OUT_W    = 16;
    localparam int SRC_EW   = 8;
    localparam int SRC_MW   = 23;
    localparam int SRC_BIAS = 127;
    localparam int DST_BIAS = 15;
    localparam int REBIAS   = SRC_BIAS - DST_BIAS;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;
    localparam int NUM_FMT  = 3;

    typedef enum logic [1:0] {
        FMT_H16  = 2'd0,
        FMT_U11  = 2'd1,
        FMT_U10  = 2'd2,
        FMT_RSVD = 2'd3
    } sfp_fmt_e;

    // decoded source value
    typedef struct packed {
        logic               sign;
        logic               is_nan;
        logic               is_inf;
        logic               is_zero;
        logic signed [9:0]  dst_exp;   // exponent rebiased to the target
        logic [SRC_MW:0]    sig;       // significand with hidden one
    } sfp_src_t;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] code;
    } sfp_out_t;

    function automatic int frac_width(int idx);
        case (idx)
            0:       return 10;
            1:       return 6;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/sfp_classify.sv
module sfp_classify
    import sfp_pkg::*;
(
    input  logic [31:0] value_i,
    output sfp_src_t    src_o
);
    logic [SRC_EW-1:0] exp_f;
    logic [SRC_MW-1:0] man_f;
    logic              exp_ones;
    logic              exp_zero;

    always_comb begin
        exp_f    = value_i[30:23];
        man_f    = value_i[22:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;

        src_o.sign    = value_i[31];
        src_o.is_nan  = exp_ones && (man_f != '0);
        src_o.is_inf  = exp_ones && (man_f == '0);
        // single-precision denormals lie far below the target's denormal floor
        src_o.is_zero = exp_zero;
        src_o.dst_exp = $signed({2'b00, exp_f}) - 10'sd112;
        src_o.sig     = {1'b1, man_f};
    end
endmodule

// File: rtl/sfp_encode.sv
module sfp_encode
    import sfp_pkg::*;
#(
    parameter int FW       = 10,
    parameter bit HAS_SIGN = 1'b1
)(
    input  sfp_src_t         src_i,
    output logic [OUT_W-1:0] code_o
);
    localparam int W   = EXP_W + FW;
    localparam int RB  = SRC_MW - 1 - FW;   // round bit position in normal path
    localparam int LB  = SRC_MW - FW;       // lsb position in normal path

    logic [W-1:0]    norm_field;
    logic            norm_inc;
    logic [5:0]      shamt;
    logic [SRC_MW:0] den_keep;
    logic [SRC_MW:0] den_rbit_v;
    logic [SRC_MW:0] den_mask;
    logic            den_inc;
    logic [W-1:0]    den_field;
    logic [W:0]      rounded;
    logic [W-1:0]    mag;
    logic            over;
    logic            denorm;

    always_comb begin
        // normal path
        norm_field = {src_i.dst_exp[EXP_W-1:0], src_i.sig[SRC_MW-1 -: FW]};
        norm_inc   = src_i.sig[RB] & ((|src_i.sig[RB-1:0]) | src_i.sig[LB]);

        // denormal path: right shift so the field scale is 2^-14 / 2^FW
        if (src_i.dst_exp < -10'sd30)
            shamt = 6'd40;
        else
            shamt = 6'(24 - FW - int'(src_i.dst_exp));
        den_keep   = src_i.sig >> shamt;
        den_rbit_v = src_i.sig >> (shamt - 6'd1);
        den_mask   = (24'd1 << (shamt - 6'd1)) - 24'd1;
        den_inc    = den_rbit_v[0] & (((src_i.sig & den_mask) != '0) | den_keep[0]);
        den_field  = W'(den_keep);

        denorm = (src_i.dst_exp < 10'sd1);
        over   = (src_i.dst_exp >= 10'(EXP_MAX));

        if (denorm)
            rounded = {1'b0, den_field} + (W+1)'(den_inc);
        else
            rounded = {1'b0, norm_field} + (W+1)'(norm_inc);

        if (src_i.is_nan)
            mag = {EXP_W'(EXP_MAX), 1'b1, (FW-1)'(0)};
        else if (src_i.is_inf || (!src_i.is_zero && over))
            mag = {EXP_W'(EXP_MAX), FW'(0)};
        else if (src_i.is_zero)
            mag = '0;
        else
            mag = rounded[W-1:0];
    end

    generate
        if (HAS_SIGN) begin : g_signed
            assign code_o = OUT_W'({src_i.sign, mag});
        end else begin : g_unsigned
            assign code_o = (src_i.sign && !src_i.is_nan) ? '0 : OUT_W'(mag);
        end
    endgenerate
endmodule

// File: rtl/fp32_to_minifloat.sv
module fp32_to_minifloat
    import sfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_value,
    input  logic [1:0]       fmt_sel,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_code
);
    sfp_src_t         src;
    logic [OUT_W-1:0] fmt_code [NUM_FMT];
    sfp_out_t         res_d;
    sfp_out_t         res_q;

    sfp_classify u_classify (
        .value_i (in_value),
        .src_o   (src)
    );

    generate
        for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
            sfp_encode #(
                .FW       (frac_width(g)),
                .HAS_SIGN (g == 0)
            ) u_encode (
                .src_i  (src),
                .code_o (fmt_code[g])
            );
        end
    endgenerate

    always_comb begin
        res_d.valid = in_valid;
        res_d.code  = res_q.code;
        if (in_valid) begin
            case (sfp_fmt_e'(fmt_sel))
                FMT_H16: res_d.code = fmt_code[0];
                FMT_U11: res_d.code = fmt_code[1];
                FMT_U10: res_d.code = fmt_code[2];
                default: res_d.code = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_code  = res_q.code;
endmodule

// File: rtl/fp32_to_minifloat_chk.sv
module fp32_to_minifloat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_value,
    input logic [1:0]  fmt_sel,
    input logic        out_valid,
    input logic [15:0] out_code
);
    logic in_nan;
    assign in_nan = (in_value[30:23] == 8'hFF) && (in_value[22:0] != 23'd0);

    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(fmt_sel) == 2'd1) |-> (out_code[15:11] == 5'd0));

    // R8
    unsigned_negative_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(fmt_sel) != 2'd0
         && $past(in_value[31]) && !$past(in_nan)) |-> (out_code == 16'd0));

    // R6
    half_nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(fmt_sel) == 2'd0 && $past(in_nan))
        |-> (out_code[14:9] == 6'h3F && out_code[15] == $past(in_value[31])));

    // R4
    half_overflow_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(fmt_sel) == 2'd0
         && $past(in_value[30:23]) >= 8'd143 && $past(in_value[30:23]) != 8'hFF)
        |-> (out_code[14:0] == 15'h7C00));
endmodule

bind fp32_to_minifloat fp32_to_minifloat_chk u_chk (.*);

// File: tb/fp32_to_minifloat_bench.sv
module fp32_to_minifloat_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [1:0]  fmt_sel = '0;
    logic        out_valid;
    logic [15:0] out_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] exp_code;
        string       tag;
    } item_t;
    item_t sb[$];

    fp32_to_minifloat u_fp32_to_minifloat (.*);

    always #5 clk = ~clk;

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic drive(logic [31:0] v, logic [1:0] f, logic [15:0] e, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_value = v;
        fmt_sel  = f;
        sb.push_back('{e, tag});
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compare each result against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sb.size() == 0) begin
                check("R1 unexpected valid", 16'd1, 16'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, out_code, it.exp_code);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {15'd0, out_valid}, 16'd0);
        check("R1 reset code", out_code, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {15'd0, out_valid}, 16'd0);

        // 16-bit normal values and ties (R3)
        drive(32'h3F800000, 2'd0, 16'h3C00, "R3 one");
        drive(32'hC0000000, 2'd0, 16'hC000, "R3 minus two");
        drive(32'h3F801000, 2'd0, 16'h3C00, "R3 tie to even down");
        drive(32'h3F803000, 2'd0, 16'h3C02, "R3 tie to even up");
        drive(32'h477FE000, 2'd0, 16'h7BFF, "R3 largest finite");
        // overflow (R4)
        drive(32'h477FF000, 2'd0, 16'h7C00, "R4 round into inf");
        drive(32'h49742400, 2'd0, 16'h7C00, "R4 far overflow");
        drive(32'hC9742400, 2'd0, 16'hFC00, "R4 negative overflow");
        drive(32'h477E0000, 2'd1, 16'h07BF, "R4 u11 largest finite");
        // denormals (R5)
        drive(32'h33800000, 2'd0, 16'h0001, "R5 min denormal");
        drive(32'h33000000, 2'd0, 16'h0000, "R5 half floor tie");
        drive(32'h33400000, 2'd0, 16'h0001, "R5 above half floor");
        drive(32'h387FFFFF, 2'd0, 16'h0400, "R5 round to min normal");
        drive(32'h38800000, 2'd0, 16'h0400, "R5 min normal");
        drive(32'h36000000, 2'd2, 16'h0001, "R5 u10 min denormal");
        // NaN (R6)
        drive(32'h7FC00001, 2'd0, 16'h7E00, "R6 half nan");
        drive(32'hFF800001, 2'd0, 16'hFE00, "R6 half negative nan");
        drive(32'hFFC00000, 2'd1, 16'h07E0, "R6 u11 negative nan");
        drive(32'h7FC00000, 2'd2, 16'h03F0, "R6 u10 nan");
        // inf and zero (R7)
        drive(32'h7F800000, 2'd0, 16'h7C00, "R7 half inf");
        drive(32'hFF800000, 2'd0, 16'hFC00, "R7 half minus inf");
        drive(32'h80000000, 2'd0, 16'h8000, "R7 half minus zero");
        drive(32'h00000001, 2'd0, 16'h0000, "R7 source denormal");
        drive(32'h7F800000, 2'd1, 16'h07C0, "R7 u11 inf");
        drive(32'h7F800000, 2'd2, 16'h03E0, "R7 u10 inf");
        // negative clamp (R8)
        drive(32'hBF800000, 2'd1, 16'h0000, "R8 u11 minus one");
        drive(32'hFF800000, 2'd1, 16'h0000, "R8 u11 minus inf");
        drive(32'hBF000000, 2'd2, 16'h0000, "R8 u10 minus half");
        drive(32'h80000000, 2'd2, 16'h0000, "R8 u10 minus zero");
        idle();
        idle();
        check("R1 bubble drains", {15'd0, out_valid}, 16'd0);
        // unsigned layout and rounding (R9)
        drive(32'h3F800000, 2'd1, 16'h03C0, "R9 u11 one");
        drive(32'h3F810000, 2'd1, 16'h03C0, "R9 u11 tie down");
        drive(32'h3F830000, 2'd1, 16'h03C2, "R9 u11 tie up");
        drive(32'h3F800000, 2'd2, 16'h01E0, "R9 u10 one");
        drive(32'h40000000, 2'd2, 16'h0200, "R9 u10 two");
        drive(32'h3F860000, 2'd2, 16'h01E2, "R9 u10 tie up");
        // select codes (R2)
        drive(32'h3F800000, 2'd3, 16'h0000, "R2 reserved select");
        drive(32'hC0000000, 2'd3, 16'h0000, "R2 reserved negative");
        drive(32'h3F800000, 2'd0, 16'h3C00, "R2 back to half");
        idle();
        idle();
        idle();
        check("R1 scoreboard empty", 16'(sb.size()), 16'd0);
        finish_run();
    end
endmodule